// File: doc/BRIEF.md
# Banked Clock Divider and Rate Selector

This block takes one fast clock and makes two slower clocks from it, one at half its rate and one at a quarter of its rate. Both have a 50% duty cycle whatever the duty cycle of the input. Twelve clock outputs carry these clocks. Nine of them form three banks of three, and a 2-bit rate select chooses, bank by bank, whether a bank carries the half-rate or the quarter-rate clock. The last three outputs always carry the half-rate clock, so one output fit for a feedback path exists in every configuration.

An active-low output enable drives a per-output drive-enable vector, which is the tri-state control for the pads. When the enable falls, the quarter-rate divider clears, so every slow output restarts in a known phase. A bypass input moves the dividers off the fast clock and onto a separate reference clock. A change of rate select is held and takes effect only when both divided clocks are low, so no output produces a short pulse.

The block has no data stream. All pins are plain control or clock pins, so no valid/ready handshake or back-pressure applies.

Top module: `clkbank_divsel`

## Requirements
- R1: A synchronous active-high reset clears both dividers and holds every clk_out bit at 0. On the first divider-clock edge after reset is released, the half-rate and quarter-rate clocks both go to 1.
- R2: The half-rate clock changes level on every divider-clock edge, so it is high for one cycle and low for one cycle.
- R3: The quarter-rate clock is high for two divider cycles and low for two. Each of its rising edges falls on a rising edge of the half-rate clock.
- R4: Bank b is made of clk_out[3b+2:3b]. It carries the quarter-rate clock when rate_sel is greater than b and the half-rate clock otherwise. So 0 puts every bank at half rate, 1 puts bank 0 at quarter rate, 2 puts banks 0 and 1 at quarter rate, and 3 puts all three banks at quarter rate.
- R5: A new rate_sel value is registered and applied only on an edge after which both divided clocks are low. The first difference between a changed bank and clk_out[9] is therefore a quarter-rate high while the half-rate clock is low.
- R6: out_en is all ones while oe_n is 0 and all zeros while oe_n is 1. It follows oe_n without waiting for a clock edge.
- R7: On the first divider-clock edge that sees oe_n low after it was high, the quarter-rate divider clears to 0. The quarter-rate outputs then next rise on the next rising edge of the half-rate clock.
- R8: While bypass is 1, the dividers run on ref_clk rather than clk. The outputs still have a 50% duty cycle even when ref_clk does not.
- R9: clk_out[11:9] carry the half-rate clock for every rate_sel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that feeds the dividers in normal operation |
| ref_clk | input | 1 | Reference clock that feeds the dividers while bypass is high |
| rst | input | 1 | Synchronous active-high reset, sampled on the divider clock |
| bypass | input | 1 | 1 selects ref_clk as the divider clock, 0 selects clk |
| oe_n | input | 1 | Active-low output enable; its falling edge clears the quarter-rate divider |
| rate_sel | input | 2 | Number of banks, counted from bank 0, that carry the quarter-rate clock |
| clk_out | output | 12 | Clock values for the twelve outputs |
| out_en | output | 12 | Drive enable for each output; 0 means high impedance |

## Verification
On every divider-clock edge, the assertions check that the half-rate clock alternates and that quarter-rate rises land on half-rate rises. They also check that a falling enable clears the quarter divider, that the applied select changes only into a both-low state, and that the fixed outputs follow the half-rate clock. Only the bench scenarios can show the overall mapping at the ports. That covers the bank-to-rate mapping for each select value, the phase of the first divergence after a select change, the restart phase after an enable fall, and the drive-enable response. It also covers whether the outputs really advance on ref_clk and not on clk in bypass, with a reference whose duty cycle is not 50%.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  localparam int NUM_BANKS  = 3;
  localparam int BANK_W     = 3;
  localparam int FIXED_OUTS = 3;

  // Present and next-state values of the two divided clocks
  typedef struct packed {
    logic half;
    logic quarter;
  } divclk_t;
endpackage

// File: rtl/clkbank_src_mux.sv
module clkbank_src_mux (
  input  logic clk,
  input  logic ref_clk,
  input  logic bypass,
  output logic div_clk
);
  // Clock source for the dividers: the reference clock in bypass mode, the fast clock otherwise
  assign div_clk = bypass ? ref_clk : clk;
endmodule

// File: rtl/clkbank_divider.sv
module clkbank_divider
  import clkbank_pkg::*;
(
  input  logic    div_clk,
  input  logic    rst,
  input  logic    oe_n,
  output divclk_t cur,
  output divclk_t nxt,
  output logic    oe_fall
);
  logic oe_q;

  // Falling edge of the output enable, seen on the divider clock
  assign oe_fall = oe_q & ~oe_n;

  always_comb begin
    nxt.half    = ~cur.half;
    // quarter toggles as half goes 0->1, so its rises line up with half's rises
    nxt.quarter = oe_fall ? 1'b0 : (cur.quarter ^ ~cur.half);
  end

  always_ff @(posedge div_clk) begin
    if (rst) begin
      cur  <= '0;
      oe_q <= 1'b1;
    end else begin
      cur  <= nxt;
      oe_q <= oe_n;
    end
  end

  // R2
  half_toggle_chk: assert property (@(posedge div_clk) disable iff (rst)
    !rst |=> (cur.half != $past(cur.half)));

  // R3
  q_rise_align_chk: assert property (@(posedge div_clk) disable iff (rst)
    $rose(cur.quarter) |-> $rose(cur.half));

  // R7
  oe_fall_clear_chk: assert property (@(posedge div_clk) disable iff (rst)
    oe_fall |=> !cur.quarter);
endmodule

// File: rtl/clkbank_sel_sync.sv
module clkbank_sel_sync
  import clkbank_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             div_clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rate_sel,
  input  divclk_t          cur,
  input  divclk_t          nxt,
  output logic [SEL_W-1:0] sel_nxt
);
  logic [SEL_W-1:0] sel_pend;
  logic [SEL_W-1:0] sel_act;
  logic             both_low_next;

  assign both_low_next = ~nxt.half & ~nxt.quarter;
  assign sel_nxt       = both_low_next ? sel_pend : sel_act;

  always_ff @(posedge div_clk) begin
    if (rst) begin
      sel_pend <= '0;
      sel_act  <= '0;
    end else begin
      sel_pend <= rate_sel;
      sel_act  <= sel_nxt;
    end
  end

  // R5
  sel_apply_low_chk: assert property (@(posedge div_clk) disable iff (rst)
    (sel_act != $past(sel_act)) |-> (!cur.half && !cur.quarter));
endmodule

// File: rtl/clkbank_router.sv
module clkbank_router
  import clkbank_pkg::*;
#(
  parameter int N_BANKS = 3,
  parameter int B_W     = 3,
  parameter int N_FIXED = 3,
  parameter int SEL_W   = 2,
  localparam int N_OUTS = N_BANKS * B_W + N_FIXED
) (
  input  logic              div_clk,
  input  logic              rst,
  input  divclk_t           nxt,
  input  logic [SEL_W-1:0]  sel_nxt,
  output logic [N_OUTS-1:0] outs
);
  logic [N_OUTS-1:0] outs_d;

  // Each output flop loads its value for the next state, so it never glitches
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic use_quarter;
    assign use_quarter = (int'(sel_nxt) > b);
    for (genvar k = 0; k < B_W; k++) begin : g_line
      assign outs_d[b*B_W + k] = use_quarter ? nxt.quarter : nxt.half;
    end
  end

  for (genvar f = 0; f < N_FIXED; f++) begin : g_fixed
    assign outs_d[N_BANKS*B_W + f] = nxt.half;
  end

  always_ff @(posedge div_clk) begin
    if (rst) outs <= '0;
    else     outs <= outs_d;
  end
endmodule

// File: rtl/clkbank_divsel.sv
module clkbank_divsel
  import clkbank_pkg::*;
#(
  parameter int N_BANKS = NUM_BANKS,
  parameter int B_W     = BANK_W,
  parameter int N_FIXED = FIXED_OUTS,
  localparam int SEL_W  = $clog2(N_BANKS + 1),
  localparam int N_OUTS = N_BANKS * B_W + N_FIXED
) (
  input  logic              clk,
  input  logic              ref_clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic              oe_n,
  input  logic [SEL_W-1:0]  rate_sel,
  output logic [N_OUTS-1:0] clk_out,
  output logic [N_OUTS-1:0] out_en
);
  logic             div_clk;
  logic             oe_fall;
  divclk_t          cur;
  divclk_t          nxt;
  logic [SEL_W-1:0] sel_nxt;

  clkbank_src_mux u_src (
    .clk     (clk),
    .ref_clk (ref_clk),
    .bypass  (bypass),
    .div_clk (div_clk)
  );

  clkbank_divider u_div (
    .div_clk (div_clk),
    .rst     (rst),
    .oe_n    (oe_n),
    .cur     (cur),
    .nxt     (nxt),
    .oe_fall (oe_fall)
  );

  clkbank_sel_sync #(.SEL_W(SEL_W)) u_sel (
    .div_clk  (div_clk),
    .rst      (rst),
    .rate_sel (rate_sel),
    .cur      (cur),
    .nxt      (nxt),
    .sel_nxt  (sel_nxt)
  );

  clkbank_router #(
    .N_BANKS (N_BANKS),
    .B_W     (B_W),
    .N_FIXED (N_FIXED),
    .SEL_W   (SEL_W)
  ) u_route (
    .div_clk (div_clk),
    .rst     (rst),
    .nxt     (nxt),
    .sel_nxt (sel_nxt),
    .outs    (clk_out)
  );

  // Pad drive enables: every output is released to high impedance while oe_n is high
  assign out_en = {N_OUTS{~oe_n}};

  // R9
  fixed_half_chk: assert property (@(posedge div_clk) disable iff (rst)
    clk_out[N_OUTS-1] == cur.half);
endmodule

// File: tb/clkbank_divsel_test.sv
`timescale 1ns/100ps
module clkbank_divsel_test;
  logic        clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst, bypass, oe_n;
  logic [1:0]  rate_sel;
  logic [11:0] clk_out, out_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [11:0] smp [0:15];
  int          tg, exp_t, first;
  bit          align;

  // {rate_sel, expected quarter-rate output mask} (R4)
  localparam logic [13:0] VEC [4] = '{
    {2'd0, 12'h000}, {2'd1, 12'h007}, {2'd2, 12'h03F}, {2'd3, 12'h1FF}
  };

  clkbank_divsel uut (
    .clk(clk), .ref_clk(ref_clk), .rst(rst), .bypass(bypass),
    .oe_n(oe_n), .rate_sel(rate_sel), .clk_out(clk_out), .out_en(out_en)
  );

  always #2.5 clk = ~clk;
  // reference with one-third duty cycle
  always begin
    ref_clk = 1'b1; #10;
    ref_clk = 1'b0; #20;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bypass = 1'b0; oe_n = 1'b1; rate_sel = 2'd0;
    repeat (3) tick();
    check(clk_out == 12'h000, "R1 outputs low in reset", clk_out, 12'h000);
    check(out_en == 12'h000, "R6 high impedance while oe_n high", out_en, 12'h000);
    rst = 1'b0;
    tick();
    check(clk_out == 12'hFFF, "R1 first edge after reset", clk_out, 12'hFFF);
    oe_n = 1'b0;
    #1;
    check(out_en == 12'hFFF, "R6 drive when oe_n low", out_en, 12'hFFF);

    // Table walk: rate for every output under each select value (R2 R3 R4 R9)
    for (int v = 0; v < 4; v++) begin
      rate_sel = VEC[v][13:12];
      repeat (10) tick();
      for (int s = 0; s < 9; s++) begin
        tick();
        smp[s] = clk_out;
      end
      for (int o = 0; o < 12; o++) begin
        tg = 0;
        align = 1'b1;
        for (int s = 1; s < 9; s++) begin
          if (smp[s][o] != smp[s-1][o]) tg++;
          if (smp[s][o] && !smp[s-1][o] && !(smp[s][9] && !smp[s-1][9])) align = 1'b0;
        end
        exp_t = VEC[v][o] ? 4 : 8;
        check(tg == exp_t && align,
              (o >= 9) ? "R9 fixed half rate" :
              (VEC[v][o] ? "R3/R4 quarter bank" : "R2/R4 half bank"), tg, exp_t);
      end
    end

    // R5: switch all banks from half to quarter, look at the first divergence
    rate_sel = 2'd0;
    repeat (10) tick();
    rate_sel = 2'd3;
    first = -1;
    for (int s = 0; s < 12; s++) begin
      tick();
      smp[s] = clk_out;
      if (first < 0 && clk_out[0] != clk_out[9]) first = s;
    end
    check(first >= 2 && first < 10, "R5 select applied within window", first, 2);
    if (first >= 2) begin
      check(smp[first][0] && !smp[first][9] && smp[first-1][0] && smp[first-1][9],
            "R5 divergence starts at both-low boundary", {smp[first][0], smp[first][9]}, 2'b10);
      check(smp[first][3] == smp[first][0] && smp[first][6] == smp[first][0],
            "R5 all banks switch together", {smp[first][6], smp[first][3]}, {2{smp[first][0]}});
    end

    // R7: drop oe_n while the quarter clock would stay high
    oe_n = 1'b1;
    #1;
    check(out_en == 12'h000, "R6 release on oe_n high", out_en, 12'h000);
    repeat (4) tick();
    while (!(clk_out[0] && clk_out[9])) tick();
    oe_n = 1'b0;
    tick();
    check(clk_out[0] == 1'b0, "R7 quarter cleared on enable fall", clk_out[0], 0);
    check(clk_out[9] == 1'b0, "R7 half clock keeps running", clk_out[9], 0);
    tick();
    check(clk_out[0] == 1'b1 && clk_out[9] == 1'b1, "R7 restart on next half rise",
          {clk_out[0], clk_out[9]}, 2'b11);

    // R1: reset in mid-run
    rst = 1'b1;
    tick();
    check(clk_out == 12'h000, "R1 reset mid-run", clk_out, 12'h000);
    rst = 1'b0;
    rate_sel = 2'd1;
    repeat (10) tick();

    // R8: bypass onto the reference clock
    bypass = 1'b1;
    repeat (6) @(negedge ref_clk);
    for (int s = 0; s < 9; s++) begin
      @(negedge ref_clk);
      smp[s] = clk_out;
    end
    tg = 0;
    for (int s = 1; s < 9; s++) if (smp[s][9] != smp[s-1][9]) tg++;
    check(tg == 8, "R8 half rate on reference clock", tg, 8);
    tg = 0;
    for (int s = 1; s < 9; s++) if (smp[s][0] != smp[s-1][0]) tg++;
    check(tg == 4, "R8 quarter rate on reference clock", tg, 4);
    tg = 0;
    for (int s = 1; s < 9; s++) if (smp[s][3] != smp[s-1][3]) tg++;
    check(tg == 8, "R8 unselected bank half rate", tg, 8);
    bypass = 1'b0;
    repeat (4) tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule